// File: doc/BRIEF.md
# Multibit Trie Longest-Prefix Lookup Engine

The engine resolves a 32-bit IPv4 destination address to a next-hop value by finding the longest stored prefix that covers the address. The routing table lives in an external synchronous SRAM as a bitmap-compressed multibit trie. Each node covers four address bits. The engine reads one node per memory access, starting from the most significant nibble of the address.

At every node the engine looks for the longest prefix that ends inside the node and matches the current nibble. It keeps the result address of the best match found so far. When the node has no child for the next nibble, the walk ends. The engine then makes one more read to fetch the stored next hop, or reports a miss if nothing matched. Only one lookup is in flight at a time. Requests and results use valid/ready handshakes. The memory port allows one outstanding read with any response latency.

Top module: `trie_lpm_engine`

## Requirements
- R1: While reset is held and just after it is released, `req_ready_o` is 1, `res_valid_o` is 0 and `mem_req_o` is 0.
- R2: The reported next hop belongs to the longest stored prefix that covers the address. Longer prefixes override shorter ones, including the zero-length default prefix. Example: with the prefixes 0/0, 10/2 and 1000000011/10 all present, address 128.252.153.160 returns the next hop of the 10-bit prefix.
- R3: A node word is, from MSB to LSB: a 16-bit child bitmap, a 15-bit prefix bitmap, the child base pointer (ADDR_W bits) and the result base pointer (ADDR_W bits). A prefix of length l (0 to 3) inside a node, whose remaining bits equal b, sits at prefix-bitmap bit 2^l - 1 + b. Its result word is at result base + (number of set prefix-bitmap bits below that position). The next hop is the low NH_W bits of the result word.
- R4: Node level k uses address bits [31-4k : 28-4k]. If child-bitmap bit n is set for that nibble value n, the next node is at child base + (number of set child-bitmap bits below n). Node 0 sits at ROOT_ADDR.
- R5: If no stored prefix covers the address, the result has found = 0 and next hop = 0. No result-word read is issued.
- R6: A lookup issues exactly one read per node visited, plus one result-word read when a match exists. That is at most 9 reads.
- R7: At level 7 (the last nibble), the child bitmap is ignored and the walk ends there.
- R8: Once a request is accepted, `req_ready_o` stays 0 until the result has been taken with `res_valid_o` and `res_ready_i` both high.
- R9: While `res_valid_o` is 1 and `res_ready_i` is 0, the result stays valid and its found flag and next hop do not change.
- R10: `mem_req_o` is a one-cycle pulse. No new read is requested until the previous read's `mem_rvalid_i` has arrived.
- R11: When the memory returns data in the cycle after the request, `res_valid_o` rises no later than 18 clock cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Engine idle, request accepted |
| req_addr_i | input | KEY_W | Destination address to resolve |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result consumer ready |
| res_found_o | output | 1 | A prefix matched |
| res_next_hop_o | output | NH_W | Next hop of the longest match, 0 on a miss |
| mem_req_o | output | 1 | SRAM read request pulse |
| mem_addr_o | output | ADDR_W | SRAM word address |
| mem_rvalid_i | input | 1 | SRAM read data valid |
| mem_rdata_i | input | MEM_W | SRAM read data (node or result word) |

## Verification
The assertions assume the memory returns exactly one `mem_rvalid_i` per request and never an unsolicited one. They also assume the trie contents are well formed: every set child or prefix bit has a word at the address its pointer and rank give.

The bench memory model answers each request once, after a programmable delay. It holds its contents fixed while a lookup is running. The trie image is built by the bench from its prefix list, so pointers and ranks always agree.

The one deliberate exception is a corrupted child bitmap at the last level. It is planted to show that the engine never reaches the bad pointer. Requests stay asserted with a stable address until they are accepted.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NODE_REQ,
    ST_NODE_WAIT,
    ST_RES_REQ,
    ST_RES_WAIT,
    ST_DONE
  } lpm_state_e;
endpackage

// File: rtl/lpm_rank.sv
`timescale 1ns/1ps
// Counts set bits of vec_i strictly below position pos_i.
module lpm_rank #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  vec_i,
  input  logic [IW-1:0] pos_i,
  output logic [IW:0]   cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      if ((i < int'(pos_i)) && vec_i[i]) cnt_o = cnt_o + (IW+1)'(1);
    end
  end
endmodule

// File: rtl/lpm_node_eval.sv
`timescale 1ns/1ps
module lpm_node_eval #(
  parameter int STRIDE = 4,
  parameter int ADDR_W = 12,
  localparam int INT_W = (1 << STRIDE) - 1,
  localparam int EXT_W = 1 << STRIDE,
  localparam int IDX_W = $clog2(EXT_W)
) (
  input  logic [INT_W-1:0]  int_bmp_i,
  input  logic [EXT_W-1:0]  ext_bmp_i,
  input  logic [ADDR_W-1:0] child_base_i,
  input  logic [ADDR_W-1:0] res_base_i,
  input  logic [STRIDE-1:0] bits_i,
  output logic              int_hit_o,
  output logic [ADDR_W-1:0] int_addr_o,
  output logic              child_hit_o,
  output logic [ADDR_W-1:0] child_addr_o
);
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W:0]   int_rank;
  logic [IDX_W:0]   ext_rank;

  // Longest internal match wins: later (longer) lengths override.
  always_comb begin
    int_hit_o = 1'b0;
    hit_idx   = '0;
    for (int l = 0; l < STRIDE; l++) begin
      int c;
      c = (1 << l) - 1 + int'(bits_i >> (STRIDE - l));
      if (int_bmp_i[c[IDX_W-1:0]]) begin
        int_hit_o = 1'b1;
        hit_idx   = c[IDX_W-1:0];
      end
    end
  end

  lpm_rank #(.W(INT_W), .IW(IDX_W)) i_int_rank (
    .vec_i(int_bmp_i), .pos_i(hit_idx), .cnt_o(int_rank)
  );

  lpm_rank #(.W(EXT_W), .IW(IDX_W)) i_ext_rank (
    .vec_i(ext_bmp_i), .pos_i(bits_i[IDX_W-1:0]), .cnt_o(ext_rank)
  );

  assign child_hit_o  = ext_bmp_i[bits_i];
  assign int_addr_o   = res_base_i + ADDR_W'(int_rank);
  assign child_addr_o = child_base_i + ADDR_W'(ext_rank);
endmodule

// File: rtl/lpm_walk_ctrl.sv
`timescale 1ns/1ps
module lpm_walk_ctrl
  import lpm_pkg::*;
#(
  parameter int KEY_W     = 32,
  parameter int STRIDE    = 4,
  parameter int ADDR_W    = 12,
  parameter int NH_W      = 8,
  parameter int ROOT_ADDR = 0,
  localparam int LEVELS   = KEY_W / STRIDE,
  localparam int LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [KEY_W-1:0]  req_addr_i,
  output logic              req_ready_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic              res_found_o,
  output logic [NH_W-1:0]   res_next_hop_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [NH_W-1:0]   rdata_nh_i,
  output logic [STRIDE-1:0] cur_bits_o,
  input  logic              int_hit_i,
  input  logic [ADDR_W-1:0] int_addr_i,
  input  logic              child_hit_i,
  input  logic [ADDR_W-1:0] child_addr_i
);
  lpm_state_e        state_q;
  logic [KEY_W-1:0]  key_q;
  logic [LVL_W-1:0]  level_q;
  logic [ADDR_W-1:0] node_q;
  logic [ADDR_W-1:0] best_q;
  logic              best_v_q;
  logic              found_q;
  logic [NH_W-1:0]   nh_q;
  logic              last_lvl;

  assign last_lvl   = (level_q == LVL_W'(LEVELS - 1));
  assign cur_bits_o = key_q[KEY_W-1 -: STRIDE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      key_q    <= '0;
      level_q  <= '0;
      node_q   <= ADDR_W'(ROOT_ADDR);
      best_q   <= '0;
      best_v_q <= 1'b0;
      found_q  <= 1'b0;
      nh_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          key_q    <= req_addr_i;
          level_q  <= '0;
          node_q   <= ADDR_W'(ROOT_ADDR);
          best_v_q <= 1'b0;
          state_q  <= ST_NODE_REQ;
        end
        ST_NODE_REQ: state_q <= ST_NODE_WAIT;
        ST_NODE_WAIT: if (mem_rvalid_i) begin
          if (int_hit_i) begin
            best_q   <= int_addr_i;
            best_v_q <= 1'b1;
          end
          if (child_hit_i && !last_lvl) begin
            node_q  <= child_addr_i;
            level_q <= level_q + LVL_W'(1);
            key_q   <= key_q << STRIDE;
            state_q <= ST_NODE_REQ;
          end else if (int_hit_i || best_v_q) begin
            state_q <= ST_RES_REQ;
          end else begin
            found_q <= 1'b0;
            nh_q    <= '0;
            state_q <= ST_DONE;
          end
        end
        ST_RES_REQ: state_q <= ST_RES_WAIT;
        ST_RES_WAIT: if (mem_rvalid_i) begin
          found_q <= 1'b1;
          nh_q    <= rdata_nh_i;
          state_q <= ST_DONE;
        end
        ST_DONE: if (res_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o    = (state_q == ST_IDLE);
  assign res_valid_o    = (state_q == ST_DONE);
  assign res_found_o    = found_q;
  assign res_next_hop_o = nh_q;
  assign mem_req_o      = (state_q == ST_NODE_REQ) || (state_q == ST_RES_REQ);
  assign mem_addr_o     = (state_q == ST_RES_REQ) ? best_q : node_q;

  a_r8_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r9_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_next_hop_o) && $stable(res_found_o)));

  a_r10_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r5_miss_zero_hop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_found_o) |-> (res_next_hop_o == '0));

  a_r6_result_read_needs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RES_REQ) |-> best_v_q);

  a_r7_stop_at_last_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NODE_WAIT && mem_rvalid_i && last_lvl) |=> (state_q != ST_NODE_REQ));
endmodule

// File: rtl/trie_lpm_engine.sv
`timescale 1ns/1ps
module trie_lpm_engine #(
  parameter int KEY_W     = 32,
  parameter int STRIDE    = 4,
  parameter int ADDR_W    = 12,
  parameter int NH_W      = 8,
  parameter int ROOT_ADDR = 0,
  localparam int INT_W    = (1 << STRIDE) - 1,
  localparam int EXT_W    = 1 << STRIDE,
  localparam int MEM_W    = EXT_W + INT_W + 2 * ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [KEY_W-1:0]  req_addr_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic              res_found_o,
  output logic [NH_W-1:0]   res_next_hop_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [MEM_W-1:0]  mem_rdata_i
);
  logic [EXT_W-1:0]  ext_bmp;
  logic [INT_W-1:0]  int_bmp;
  logic [ADDR_W-1:0] child_base;
  logic [ADDR_W-1:0] res_base;
  logic [STRIDE-1:0] cur_bits;
  logic              int_hit;
  logic [ADDR_W-1:0] int_addr;
  logic              child_hit;
  logic [ADDR_W-1:0] child_addr;

  assign ext_bmp    = mem_rdata_i[MEM_W-1 -: EXT_W];
  assign int_bmp    = mem_rdata_i[MEM_W-EXT_W-1 -: INT_W];
  assign child_base = mem_rdata_i[2*ADDR_W-1 -: ADDR_W];
  assign res_base   = mem_rdata_i[ADDR_W-1:0];

  lpm_node_eval #(.STRIDE(STRIDE), .ADDR_W(ADDR_W)) i_node_eval (
    .int_bmp_i   (int_bmp),
    .ext_bmp_i   (ext_bmp),
    .child_base_i(child_base),
    .res_base_i  (res_base),
    .bits_i      (cur_bits),
    .int_hit_o   (int_hit),
    .int_addr_o  (int_addr),
    .child_hit_o (child_hit),
    .child_addr_o(child_addr)
  );

  lpm_walk_ctrl #(
    .KEY_W(KEY_W), .STRIDE(STRIDE), .ADDR_W(ADDR_W),
    .NH_W(NH_W), .ROOT_ADDR(ROOT_ADDR)
  ) i_walk_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_addr_i    (req_addr_i),
    .req_ready_o   (req_ready_o),
    .res_valid_o   (res_valid_o),
    .res_ready_i   (res_ready_i),
    .res_found_o   (res_found_o),
    .res_next_hop_o(res_next_hop_o),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_rvalid_i  (mem_rvalid_i),
    .rdata_nh_i    (mem_rdata_i[NH_W-1:0]),
    .cur_bits_o    (cur_bits),
    .int_hit_i     (int_hit),
    .int_addr_i    (int_addr),
    .child_hit_i   (child_hit),
    .child_addr_i  (child_addr)
  );
endmodule

// File: tb/test_trie_lpm_engine.sv
`timescale 1ns/1ps
module test_trie_lpm_engine;
  localparam int ADDR_W   = 12;
  localparam int NH_W     = 8;
  localparam int MEM_W    = 16 + 15 + 2 * ADDR_W;
  localparam int RES_BASE = 256;

  typedef struct {
    logic       found;
    logic [7:0] nh;
    int         reads;
    bit         hold;
    bit         timed;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic req_ready, res_valid, res_found, mem_req;
  logic res_ready = 1'b1;
  logic [NH_W-1:0] res_nh;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [MEM_W-1:0] mem_rdata = '0;

  logic [MEM_W-1:0] mem [512];
  int mem_lat = 0;
  int lat_cnt = 0;
  logic [8:0] lat_addr = '0;

  int n_tests = 0, n_fail = 0, cyc = 0;
  exp_t sb[$];

  logic [31:0] p_val [16];
  int p_len [16], p_nh [16];
  bit p_on [16];
  int n_pfx = 0;

  logic [31:0] n_path [64];
  int n_lvl [64], n_child [64], n_res [64];
  logic [15:0] n_ext [64];
  logic [14:0] n_int [64];
  int n_cnt = 0;

  bit busy = 0, viol_ready = 0, viol_out = 0, outst = 0, prev_valid = 0, was_held = 0;
  int reads_cnt = 0, acc_cyc = 0, first_cyc = 0;
  logic held_found = 1'b0;
  logic [NH_W-1:0] held_nh = '0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  trie_lpm_engine #(.ADDR_W(ADDR_W), .NH_W(NH_W)) i_trie_lpm_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .res_valid_o(res_valid), .res_ready_i(res_ready),
    .res_found_o(res_found), .res_next_hop_o(res_nh),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  // SRAM model: one response per request after mem_lat extra cycles
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      if (mem_lat == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[8:0]];
      end else begin
        lat_cnt  <= mem_lat;
        lat_addr <= mem_addr[8:0];
      end
    end else if (lat_cnt != 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[lat_addr];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic add_pfx(input logic [31:0] v, input int len, input int nh);
    p_val[n_pfx] = v; p_len[n_pfx] = len; p_nh[n_pfx] = nh; p_on[n_pfx] = 1'b1;
    n_pfx++;
  endtask

  function automatic bit covers(input logic [31:0] v, input int len, input logic [31:0] a);
    if (len == 0) return 1'b1;
    return (a >> (32 - len)) == (v >> (32 - len));
  endfunction

  function automatic bit node_needed(input int lv, input logic [31:0] path);
    for (int p = 0; p < n_pfx; p++)
      if (p_on[p] && p_len[p] >= 4*lv && (p_val[p] >> (32 - 4*lv)) == path) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int slot_of(input int p, input int lv, input logic [31:0] path);
    int l, b;
    if (p_len[p] < 4*lv || p_len[p] > 4*lv + 3) return -1;
    if (lv != 0 && (p_val[p] >> (32 - 4*lv)) != path) return -1;
    l = p_len[p] - 4*lv;
    b = (l == 0) ? 0 : int'((p_val[p] >> (32 - p_len[p])) & ((32'd1 << l) - 1));
    return (1 << l) - 1 + b;
  endfunction

  task automatic build_trie();
    int rp;
    for (int i = 0; i < 512; i++) mem[i] = '0;
    n_cnt = 1; n_path[0] = '0; n_lvl[0] = 0; n_ext[0] = '0; n_child[0] = 0;
    for (int i = 0; i < n_cnt; i++) begin
      if (n_lvl[i] < 7) begin
        for (int nb = 0; nb < 16; nb++) begin
          logic [31:0] cp;
          cp = (n_path[i] << 4) | 32'(nb);
          if (node_needed(n_lvl[i] + 1, cp)) begin
            if (n_ext[i] == '0) n_child[i] = n_cnt;
            n_ext[i][nb] = 1'b1;
            n_path[n_cnt] = cp; n_lvl[n_cnt] = n_lvl[i] + 1;
            n_ext[n_cnt] = '0; n_child[n_cnt] = 0;
            n_cnt++;
          end
        end
      end
    end
    rp = RES_BASE;
    for (int i = 0; i < n_cnt; i++) begin
      n_int[i] = '0; n_res[i] = rp;
      for (int idx = 0; idx < 15; idx++)
        for (int p = 0; p < n_pfx; p++)
          if (p_on[p] && slot_of(p, n_lvl[i], n_path[i]) == idx) begin
            n_int[i][idx] = 1'b1;
            mem[rp] = MEM_W'(p_nh[p]);
            rp++;
          end
      mem[i] = {n_ext[i], n_int[i], ADDR_W'(n_child[i]), ADDR_W'(n_res[i])};
    end
  endtask

  task automatic expect_of(input logic [31:0] a, output logic f, output logic [7:0] nh,
                           output int rd);
    int best;
    best = -1; nh = '0;
    for (int p = 0; p < n_pfx; p++)
      if (p_on[p] && covers(p_val[p], p_len[p], a) && p_len[p] > best) begin
        best = p_len[p]; nh = 8'(p_nh[p]);
      end
    f = (best >= 0);
    rd = 1;
    for (int lv = 1; lv < 8; lv++) begin
      if (!node_needed(lv, a >> (32 - 4*lv))) break;
      rd++;
    end
    if (f) rd++;
  endtask

  task automatic do_lookup(input logic [31:0] a, input int hold, input string tag);
    exp_t e;
    logic f;
    logic [7:0] nh;
    int rd;
    expect_of(a, f, nh, rd);
    e.found = f; e.nh = nh; e.reads = rd; e.hold = (hold > 0);
    e.timed = (mem_lat == 0); e.tag = tag;
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; res_ready = (hold == 0);
    do @(negedge clk); while (!req_ready);
    sb.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b0; busy = 1; reads_cnt = 0; acc_cyc = cyc;
    viol_ready = 0; viol_out = 0;
    if (hold > 0) begin
      do @(negedge clk); while (!res_valid);
      repeat (hold) @(posedge clk);
      #1 res_ready = 1'b1;
    end
    do @(negedge clk); while (busy);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && outst) viol_out = 1;
      if (mem_rvalid) outst = 0;
      if (mem_req) begin outst = 1; reads_cnt++; end
      if (busy && req_ready) viol_ready = 1;
      if (res_valid && !prev_valid) begin
        first_cyc = cyc; held_nh = res_nh; held_found = res_found;
      end
      if (res_valid && !res_ready) was_held = 1;
      if (res_valid && res_ready) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8", "unexpected result", 32'(res_nh), 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(res_found == e.found, e.tag, "found flag", 32'(res_found), 32'(e.found));
          chk(res_nh == e.nh, e.tag, "next hop", 32'(res_nh), 32'(e.nh));
          chk(reads_cnt == e.reads, "R6", "memory reads", reads_cnt, e.reads);
          chk(!viol_ready, "R8", "ready while busy", 32'(viol_ready), 0);
          chk(!viol_out, "R10", "overlapping reads", 32'(viol_out), 0);
          if (e.timed)
            chk((first_cyc - acc_cyc) <= 18, "R11", "latency", first_cyc - acc_cyc, 18);
          if (e.hold)
            chk(was_held && res_nh == held_nh && res_found == held_found, "R9",
                "held result", 32'(res_nh), 32'(held_nh));
        end
        busy = 0; was_held = 0;
      end
      prev_valid = res_valid && !res_ready;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", cyc, 100000);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int k7;
    add_pfx(32'h0000_0000, 0, 5);
    add_pfx(32'h8000_0000, 2, 12);
    add_pfx(32'h80C0_0000, 10, 7);
    add_pfx(32'h0A00_0000, 8, 20);
    add_pfx(32'h0A01_0000, 16, 21);
    add_pfx(32'hC0A8_0100, 24, 30);
    add_pfx(32'hC0A8_0180, 25, 31);
    add_pfx(32'hC0A8_0190, 28, 32);
    add_pfx(32'hFFFF_FFFE, 31, 40);
    add_pfx(32'h6000_0000, 3, 3);
    add_pfx(32'h2000_0000, 4, 4);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", 32'(req_ready), 1);
    chk(res_valid == 1'b0, "R1", "valid in reset", 32'(res_valid), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && res_valid == 1'b0 && mem_req == 1'b0, "R1", "after release",
        {29'd0, req_ready, res_valid, mem_req}, 32'h4);

    // Table without default route, single-cycle memory
    p_on[0] = 1'b0;
    build_trie();
    mem_lat = 0;
    do_lookup(32'h0A01_0203, 0, "R2");
    do_lookup(32'h0B00_0000, 0, "R5");
    do_lookup(32'h5000_0000, 0, "R5");
    do_lookup(32'h80FC_99A0, 0, "R2");
    do_lookup(32'hC0A8_0195, 0, "R4");
    do_lookup(32'hC0A8_01A0, 0, "R3");
    do_lookup(32'hC0A8_0105, 0, "R3");
    do_lookup(32'hFFFF_FFFF, 0, "R11");

    // Default route present, slow memory, held results
    p_on[0] = 1'b1;
    build_trie();
    mem_lat = 2;
    do_lookup(32'h5000_0000, 0, "R2");
    do_lookup(32'h80FC_99A0, 3, "R9");
    do_lookup(32'h8100_0000, 0, "R2");
    do_lookup(32'h6000_0001, 0, "R3");
    do_lookup(32'h2F00_0000, 2, "R4");
    do_lookup(32'hC0A8_0195, 0, "R10");

    // R7: corrupt the last-level child bitmap; walk must still end there
    k7 = -1;
    for (int i = 0; i < n_cnt; i++)
      if (n_lvl[i] == 7 && n_path[i] == 32'h0FFF_FFFF) k7 = i;
    chk(k7 >= 0, "R7", "last-level node present", k7, 0);
    if (k7 >= 0) begin
      mem[k7][MEM_W-1 -: 16] = 16'hFFFF;
      mem[k7][2*ADDR_W-1 -: ADDR_W] = ADDR_W'(500);
    end
    mem_lat = 1;
    do_lookup(32'hFFFF_FFFF, 0, "R7");
    do_lookup(32'hFFFF_FFF0, 0, "R7");

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R8", "results outstanding", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule